// File: doc/BRIEF.md
# Scrolling Scan Line Address Counter

This block produces the display-memory row address for each common line of an LCD frame. A 6-bit start-line register holds the memory row that should be shown on the first common line. On every frame-start pulse the register is copied into a separate 6-bit scan counter, and each line-clock pulse then advances that counter by one. Writing a new start line therefore scrolls the picture vertically without rewriting display memory.

A frame has 65 line periods. The first 64 take their address from the scan counter, which wraps from 63 back to 0. The 65th period always selects the fixed icon row at address 64, whatever the start line is, and raises an icon flag. A single-cycle fetch strobe marks every new address, so the row latch that follows can start its transfer. Writes to the start line are accepted at any time but only take effect at the next frame start.

Top module: `scan_row_addr`

## Requirements
- R1: After reset `row_addr` is 0, `row_fetch` and `icon_sel` are low, and the start line is 0, so a frame started without any write first presents row 0.
- R2: A `start_wr` pulse stores `start_data` as the start line. A `frame_start` pulse sampled on a clock edge makes `row_addr` equal the stored start line one cycle later, with `row_fetch` high and `icon_sel` low.
- R3: Each `line_tick` during the scrolled part of a frame presents the previous address plus one, wrapping from 63 to 0, one cycle after the tick.
- R4: A start-line write during a frame leaves the rest of that frame unchanged and applies from the next `frame_start`. A write in the same cycle as `frame_start` is not used by that frame.
- R5: The `line_tick` that follows the 64th scrolled line presents row address 64 with `icon_sel` high, whatever the start line is.
- R6: `row_fetch` is high for exactly one cycle for each address that is presented, and is low in every cycle with no accepted `frame_start` or `line_tick` on the edge before.
- R7: A `line_tick` before the first `frame_start`, or after the icon row of a frame, is ignored: no strobe, and `row_addr` and `icon_sel` hold.
- R8: When `frame_start` and `line_tick` arrive in the same cycle, the frame start wins and the start line is presented.
- R9: `icon_sel` is high only together with `row_addr` equal to 64, and in the scrolled lines `row_addr` stays below 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| line_tick | input | 1 | One-cycle pulse advancing to the next common line |
| start_wr | input | 1 | Write enable for the start-line register |
| start_data | input | 6 | Start-line value to store |
| row_addr | output | 7 | Display-memory row address, 0 to 63 for scrolled rows, 64 for the icon row |
| row_fetch | output | 1 | One-cycle strobe when a new row address is presented |
| icon_sel | output | 1 | High while the icon row is selected |

## Verification
Every cycle the assertions check that a frame start loads the stored start line, that a strobed scrolled address is the previous one plus one modulo 64, that the icon flag comes only with address 64, that outputs hold when no strobe fires, and that the start line changes only on a write. Only the bench scenarios show whole frames: the wrap from 63 to 0 at a chosen start line, the exact line on which the icon row appears, the deferral of a mid-frame write to the next frame, and ticks ignored outside a frame.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Sequencer position within a frame.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,  // no frame started yet
    PH_SCROLL = 2'd1,  // scrolled lines, counter supplies the address
    PH_ICON   = 2'd2   // icon row presented, waiting for next frame
  } scan_phase_e;

endpackage

// File: rtl/start_line_reg.sv
module start_line_reg #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] start_q
);

  logic [ADDR_W-1:0] start_d;

  always_comb begin
    start_d = start_q;
    if (wr_en) begin
      start_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
    end else begin
      start_q <= start_d;
    end
  end

endmodule

// File: rtl/line_counter.sv
module line_counter #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] cnt_d
);

  logic [ADDR_W-1:0] cnt_q;

  // Load has priority; the step wraps naturally at 2**ADDR_W.
  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = cnt_q + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import scan_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic line_tick,
  output logic load,
  output logic step,
  output logic enter_icon
);

  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  scan_phase_e       phase_q, phase_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic              adv;

  always_comb begin
    phase_d    = phase_q;
    idx_d      = idx_q;
    load       = 1'b0;
    step       = 1'b0;
    enter_icon = 1'b0;
    adv        = line_tick && (phase_q == PH_SCROLL);
    if (frame_start) begin
      load    = 1'b1;
      phase_d = PH_SCROLL;
      idx_d   = '0;
    end else if (adv) begin
      if (idx_q == LAST_IDX) begin
        enter_icon = 1'b1;
        phase_d    = PH_ICON;
      end else begin
        step  = 1'b1;
        idx_d = idx_q + ADDR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/row_output_stage.sv
module row_output_stage #(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              present,
  input  logic              icon,
  input  logic [ADDR_W-1:0] scan_addr,
  output logic [ROW_W-1:0]  row_addr,
  output logic              row_fetch,
  output logic              icon_sel
);

  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(1 << ADDR_W);

  logic [ROW_W-1:0] addr_d;
  logic             icon_d;
  logic             fetch_d;

  always_comb begin
    addr_d  = row_addr;
    icon_d  = icon_sel;
    fetch_d = present;
    if (present) begin
      icon_d = icon;
      addr_d = icon ? ICON_ROW : ROW_W'(scan_addr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_addr  <= '0;
      icon_sel  <= 1'b0;
      row_fetch <= 1'b0;
    end else begin
      row_addr  <= addr_d;
      icon_sel  <= icon_d;
      row_fetch <= fetch_d;
    end
  end

endmodule

// File: rtl/scan_row_addr.sv
module scan_row_addr #(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_tick,
  input  logic              start_wr,
  input  logic [ADDR_W-1:0] start_data,
  output logic [ROW_W-1:0]  row_addr,
  output logic              row_fetch,
  output logic              icon_sel
);

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[1];

  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] scan_addr;
  logic              seq_load;
  logic              seq_step;
  logic              seq_icon;
  logic              seq_present;

  start_line_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (start_wr),
    .wr_data (start_data),
    .start_q (start_q)
  );

  frame_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .frame_start (frame_start),
    .line_tick   (line_tick),
    .load        (seq_load),
    .step        (seq_step),
    .enter_icon  (seq_icon)
  );

  line_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (seq_load),
    .load_val (start_q),
    .step     (seq_step),
    .cnt_d    (scan_addr)
  );

  assign seq_present = seq_load | seq_step | seq_icon;

  row_output_stage #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .present   (seq_present),
    .icon      (seq_icon),
    .scan_addr (scan_addr),
    .row_addr  (row_addr),
    .row_fetch (row_fetch),
    .icon_sel  (icon_sel)
  );

endmodule

// File: rtl/scan_row_addr_chk.sv
module scan_row_addr_chk #(
  parameter int ADDR_W = 6,
  parameter int ROW_W  = ADDR_W + 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              frame_start,
  input logic              line_tick,
  input logic              start_wr,
  input logic [ADDR_W-1:0] start_q,
  input logic [ROW_W-1:0]  row_addr,
  input logic              row_fetch,
  input logic              icon_sel
);

  localparam logic [ROW_W-1:0] ICON_ROW = ROW_W'(1 << ADDR_W);

  // R2, R4, R8: a frame start presents the start line held before that edge
  p_frame_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frame_start |=> (row_addr == ROW_W'($past(start_q))) && row_fetch && !icon_sel);

  // R3: a strobed scrolled line not caused by a frame start is previous plus one
  p_step_wrap_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (row_fetch && !icon_sel && !$past(frame_start)) |->
      (row_addr[ADDR_W-1:0] == $past(row_addr[ADDR_W-1:0]) + ADDR_W'(1)));

  // R6: no accepted event on the previous edge means no strobe
  p_no_event_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!frame_start && !line_tick) |=> !row_fetch);

  // R7: outputs hold whenever no strobe fires
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !row_fetch |-> ($stable(row_addr) && $stable(icon_sel)));

  // R9: icon flag only with the icon row, scrolled rows below it
  p_icon_row_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    icon_sel |-> (row_addr == ICON_ROW));

  p_scroll_range_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !icon_sel |-> (row_addr < ICON_ROW));

  // R4: the start line changes only through a write
  p_start_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !start_wr |=> $stable(start_q));

endmodule

bind scan_row_addr scan_row_addr_chk #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .frame_start (frame_start),
  .line_tick   (line_tick),
  .start_wr    (start_wr),
  .start_q     (start_q),
  .row_addr    (row_addr),
  .row_fetch   (row_fetch),
  .icon_sel    (icon_sel)
);

// File: tb/scan_row_addr_tb.sv
`timescale 1ns/1ps
module scan_row_addr_tb;

  localparam int ADDR_W = 6;
  localparam int ROW_W  = ADDR_W + 1;
  localparam int LINES  = 1 << ADDR_W;
  localparam int ICON   = LINES;

  logic              clk;
  logic              rst_n;
  logic              frame_start;
  logic              line_tick;
  logic              start_wr;
  logic [ADDR_W-1:0] start_data;
  logic [ROW_W-1:0]  row_addr;
  logic              row_fetch;
  logic              icon_sel;

  int vectors;
  int miscmp;
  bit done;

  scan_row_addr #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_tick   (line_tick),
    .start_wr    (start_wr),
    .start_data  (start_data),
    .row_addr    (row_addr),
    .row_fetch   (row_fetch),
    .icon_sel    (icon_sel)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Each stimulus is set at a falling edge, sampled at the next rising
  // edge, and the registered result is read at the following falling edge.
  task automatic pulse_frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk); line_tick = 1'b0;
  endtask

  task automatic write_start(input int v);
    @(negedge clk); start_wr = 1'b1; start_data = ADDR_W'(v);
    @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic chk_row(input string req, input int exp_addr, input int exp_icon);
    chk({req, " row_addr"}, int'(row_addr), exp_addr);
    chk({req, " row_fetch"}, int'(row_fetch), 1);
    chk({req, " icon_sel"}, int'(icon_sel), exp_icon);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; frame_start = 1'b0; line_tick = 1'b0;
    start_wr = 1'b0; start_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset row_addr", int'(row_addr), 0);
    chk("R1 reset row_fetch", int'(row_fetch), 0);
    chk("R1 reset icon_sel", int'(icon_sel), 0);
  endtask

  task automatic t_idle_ticks();
    pulse_tick();
    chk("R7 tick before frame row_fetch", int'(row_fetch), 0);
    chk("R7 tick before frame row_addr", int'(row_addr), 0);
    pulse_frame();
    chk_row("R1 default start line", 0, 0);
  endtask

  // Whole frame: 64 scrolled lines from s, icon row, then a late tick.
  task automatic t_full_frame(input int s);
    write_start(s);
    pulse_frame();
    chk_row("R2 frame start loads start line", s, 0);
    @(negedge clk);
    chk("R6 strobe lasts one cycle", int'(row_fetch), 0);
    for (int i = 1; i < LINES; i++) begin
      pulse_tick();
      chk_row("R3 scrolled step", (s + i) % LINES, 0);
    end
    pulse_tick();
    chk_row("R5 icon row after 64 lines", ICON, 1);
    pulse_tick();
    chk("R7 tick after icon row_fetch", int'(row_fetch), 0);
    chk("R7 tick after icon row_addr", int'(row_addr), ICON);
    chk("R9 icon flag holds with row 64", int'(icon_sel), 1);
  endtask

  task automatic t_midframe_write();
    write_start(10);
    pulse_frame();
    chk_row("R2 frame with start 10", 10, 0);
    pulse_tick();
    write_start(40);
    chk("R4 write alone gives no strobe", int'(row_fetch), 0);
    pulse_tick();
    chk_row("R4 mid-frame write ignored", 12, 0);
    pulse_frame();
    chk_row("R4 write applied at next frame", 40, 0);
  endtask

  task automatic t_same_cycle_write();
    @(negedge clk);
    frame_start = 1'b1; start_wr = 1'b1; start_data = ADDR_W'(5);
    @(negedge clk);
    frame_start = 1'b0; start_wr = 1'b0;
    chk_row("R4 same-cycle write not used", 40, 0);
    pulse_frame();
    chk_row("R4 same-cycle write used next frame", 5, 0);
  endtask

  task automatic t_priority();
    pulse_tick();
    pulse_tick();
    chk_row("R3 before priority test", 7, 0);
    @(negedge clk);
    frame_start = 1'b1; line_tick = 1'b1;
    @(negedge clk);
    frame_start = 1'b0; line_tick = 1'b0;
    chk_row("R8 frame start beats tick", 5, 0);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); line_tick = 1'b1;
    @(negedge clk);
    chk_row("R6 back-to-back first", 6, 0);
    @(negedge clk); line_tick = 1'b0;
    chk_row("R6 back-to-back second", 7, 0);
    @(negedge clk);
    chk("R6 strobe drops after ticks", int'(row_fetch), 0);
    chk("R7 address holds", int'(row_addr), 7);
  endtask

  initial begin
    vectors = 0; miscmp = 0; done = 1'b0;
    t_reset();
    t_idle_ticks();
    t_full_frame(0);
    t_full_frame(60);
    t_midframe_write();
    t_same_cycle_write();
    t_priority();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

endmodule